// File: doc/BRIEF.md
# Shaped On-Off Keying Amplitude Ramper

This block scales a signed 12-bit sample stream by a 12-bit amplitude factor. With automatic shaping enabled, the factor does not jump when the keying input changes level. It walks one code at a time between zero and full scale: up while the key is high and down while the key is low. A programmable rate count sets how many clock cycles the factor dwells on each code, so the length of a transition is the clock period times the rate count times the number of codes crossed.

When automatic shaping is disabled, a manual amplitude word drives the multiplier directly. The ramp keeps tracking the key in the background, so re-enabling shaping resumes from wherever the ramp has got to. The multiplier returns the upper twelve bits of the product, which means a full-scale factor returns close to the input sample. A busy output reports that the ramp has not yet reached the end point the key is asking for.

Top module: `ook_shaper`

## Requirements
- R1: While reset is low and on the cycle after it, with shaping enabled, the scale factor is 0, busy is low and the scaled sample is 0.
- R2: Starting at rest at 0 with the key raised, the factor reaches 4095 exactly 4095·N clock edges later, where N is the rate count. A ramp down from 4095 to 0 takes the same time.
- R3: While ramping, the factor changes by exactly one code per step. Steps are spaced exactly N cycles apart, and the first step comes N cycles after the key changes from rest.
- R4: A rate count of 0 behaves as a rate count of 1.
- R5: The factor only rises while the key is high and only falls while it is low. A reversal in the middle of a ramp continues from the current value with no jump, and the step timer keeps its phase.
- R6: With shaping disabled the scale output equals the manual word in the same cycle. The ramp still follows the key, and its level appears on the scale output as soon as shaping is re-enabled.
- R7: Busy is high exactly when the ramp level is not at the end point selected by the key (4095 for key high, 0 for key low).
- R8: The scaled sample equals floor(sample × scale / 4096), with the sample in two's complement. It appears one clock after the sample and scale are presented.
- R9: The ramp level holds at 4095 while the key stays high and at 0 while the key stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_i | input | 1 | Keying input: high ramps up, low ramps down |
| auto_en_i | input | 1 | 1 selects the shaped ramp, 0 selects the manual word |
| manual_amp_i | input | 12 | Manual amplitude factor |
| rate_i | input | 8 | Clock cycles per ramp step (0 treated as 1) |
| sample_i | input | 12 | Signed input sample |
| sample_o | output | 12 | Signed scaled sample, registered |
| scale_o | output | 12 | Scale factor currently applied |
| busy_o | output | 1 | Ramp is moving toward the key's end point |

## Verification
The scale factor and busy flag are combinational views of the ramp register, so a key change seen at one falling edge shows its first step N rising edges later. The bench therefore counts falling edges from the one where it drives the key and compares against exact multiples of N. The scaled sample is due one rising edge after its inputs. The bench records the sample and the observed scale at the falling edge where it drives them, and compares the product at the next falling edge. The manual path and busy flag are combinational and are checked one time step after driving, before any clock edge.

// File: rtl/ook_pkg.sv
// Shared types for the shaped on-off keying ramper.
// Assumes nothing beyond the 1800-2017 language.
package ook_pkg;
    // Direction the ramp level moves on the next step tick.
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } ramp_dir_e;
endpackage

// File: rtl/ook_rate_tick.sv
// Step timer: while run_i is high, pulses tick_o once every N cycles,
// where N is rate_i (0 treated as 1). The count clears whenever run_i is low,
// so the first tick after a start from rest comes N cycles later.
// Assumes rate_i may change at any time; an overrun count ticks at once.
module ook_rate_tick #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [RW-1:0] rate_i,
    output logic          tick_o
);
    localparam logic [RW-1:0] ONE = RW'(1);

    logic [RW-1:0] cnt_q;
    logic [RW-1:0] eff_rate;
    logic [RW-1:0] last_cnt;

    // Map a zero rate to one cycle per step and find the terminal count.
    always_comb begin
        eff_rate = (rate_i == '0) ? ONE : rate_i;
        last_cnt = eff_rate - ONE;
        tick_o   = run_i && (cnt_q >= last_cnt);
    end

    // Advance the dwell counter while running, clear it on tick or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/ook_ramp_acc.sv
// Ramp level register: moves one code toward the end point chosen by key_i
// on each tick, and saturates at 0 and at all-ones.
// Assumes key_i is already synchronous to clk.
module ook_ramp_acc
    import ook_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_i,
    input  logic          tick_i,
    output logic [AW-1:0] level_o,
    output logic          moving_o
);
    localparam logic [AW-1:0] LVL_MAX = {AW{1'b1}};
    localparam logic [AW-1:0] LVL_ONE = AW'(1);

    ramp_dir_e     dir;
    logic [AW-1:0] level_q;

    // Choose the direction from the key and the current level.
    always_comb begin
        if (key_i) begin
            dir = (level_q != LVL_MAX) ? DIR_UP : DIR_HOLD;
        end else begin
            dir = (level_q != '0) ? DIR_DOWN : DIR_HOLD;
        end
        moving_o = (dir != DIR_HOLD);
        level_o  = level_q;
    end

    // Take one step on each tick in the chosen direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (tick_i) begin
            unique case (dir)
                DIR_UP:   level_q <= level_q + LVL_ONE;
                DIR_DOWN: level_q <= level_q - LVL_ONE;
                default:  level_q <= level_q;
            endcase
        end
    end
endmodule

// File: rtl/ook_scaler.sv
// Registered multiplier: scales a signed sample by an unsigned factor and
// keeps the upper SW bits of the product (floor of sample*scale/2^AW).
// Assumes AW-bit factors below 2^AW, so the result always fits in SW bits.
module ook_scaler #(
    parameter int SW = 12,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sample_i,
    input  logic [AW-1:0] scale_i,
    output logic [SW-1:0] sample_o
);
    localparam int PW = SW + AW + 1;

    logic signed [PW-1:0] prod;

    // Signed product of the sample and the zero-extended factor.
    always_comb begin
        prod = PW'($signed(sample_i)) * PW'($signed({1'b0, scale_i}));
    end

    // Register the upper bits of the product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o <= '0;
        end else begin
            sample_o <= prod[SW+AW-1:AW];
        end
    end
endmodule

// File: rtl/ook_shaper.sv
// Top of the shaped on-off keying ramper: step timer, ramp level register,
// manual/automatic factor select and registered sample multiplier.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module ook_shaper #(
    parameter int SW = 12,
    parameter int AW = 12,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_i,
    input  logic          auto_en_i,
    input  logic [AW-1:0] manual_amp_i,
    input  logic [RW-1:0] rate_i,
    input  logic [SW-1:0] sample_i,
    output logic [SW-1:0] sample_o,
    output logic [AW-1:0] scale_o,
    output logic          busy_o
);
    logic          step_tick;
    logic          ramp_moving;
    logic [AW-1:0] ramp_level;

    ook_rate_tick #(.RW(RW)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (ramp_moving),
        .rate_i (rate_i),
        .tick_o (step_tick)
    );

    ook_ramp_acc #(.AW(AW)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_i    (key_i),
        .tick_i   (step_tick),
        .level_o  (ramp_level),
        .moving_o (ramp_moving)
    );

    // Pick the shaped ramp or the manual word as the applied factor.
    always_comb begin
        scale_o = auto_en_i ? ramp_level : manual_amp_i;
        busy_o  = ramp_moving;
    end

    ook_scaler #(.SW(SW), .AW(AW)) u_scale (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_i),
        .scale_i  (scale_o),
        .sample_o (sample_o)
    );
endmodule

// File: rtl/ook_shaper_chk.sv
// Property checker for ook_shaper, attached by bind below.
// Assumes the ramp level is reachable as ramp_level inside the top.
module ook_shaper_chk #(
    parameter int SW = 12,
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          key_i,
    input logic          busy_o,
    input logic [AW-1:0] level,
    input logic [SW-1:0] sample_i,
    input logic [AW-1:0] scale_o,
    input logic [SW-1:0] sample_o
);
    localparam logic [AW-1:0] TOP = {AW{1'b1}};

    logic signed [SW+AW+1:0] ref_prod;
    logic        [SW-1:0]    ref_out;

    // Independent reference product of the presented sample and factor.
    always_comb begin
        ref_prod = $signed({{(AW+2){sample_i[SW-1]}}, sample_i}) *
                   $signed({{(SW+1){1'b0}}, scale_o});
        ref_out  = ref_prod[SW+AW-1:AW];
    end

    // R3: the level moves by exactly one code at a time.
    a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |->
        ((level == $past(level) + AW'(1)) || (level + AW'(1) == $past(level))));

    // R5: rises only with the key high.
    a_r5_rise_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        (level > $past(level)) |-> $past(key_i));

    // R5: falls only with the key low.
    a_r5_fall_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        (level < $past(level)) |-> !$past(key_i));

    // R7: no movement while busy is low.
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(level));

    // R9: full scale holds while the key stays high.
    a_r9_top_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (key_i && level == TOP) |=> (level == TOP));

    // R8: scaled sample follows the presented inputs one clock later.
    a_r8_product: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (sample_o == $past(ref_out)));
endmodule

bind ook_shaper ook_shaper_chk #(.SW(SW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_i    (key_i),
    .busy_o   (busy_o),
    .level    (ramp_level),
    .sample_i (sample_i),
    .scale_o  (scale_o),
    .sample_o (sample_o)
);

// File: tb/ook_shaper_bench.sv
module ook_shaper_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        key_i;
    logic        auto_en_i;
    logic [11:0] manual_amp_i;
    logic [7:0]  rate_i;
    logic [11:0] sample_i;
    logic [11:0] sample_o;
    logic [11:0] scale_o;
    logic        busy_o;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ook_shaper u_ook_shaper (
        .clk          (clk),
        .rst_n        (rst_n),
        .key_i        (key_i),
        .auto_en_i    (auto_en_i),
        .manual_amp_i (manual_amp_i),
        .rate_i       (rate_i),
        .sample_i     (sample_i),
        .sample_o     (sample_o),
        .scale_o      (scale_o),
        .busy_o       (busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_prod(input int s, input int sc);
        int p;
        p = s * sc;
        return p >>> 12;
    endfunction

    // Ramp from rest at one end to the other; count edges and step spacing.
    task automatic ramp_run(input bit up, input int rate_val, input int n);
        int target, cyc, since, prev, bad;
        target = up ? 4095 : 0;
        rate_i = 8'(rate_val);
        key_i  = up;
        #1;
        chk(busy_o == 1'b1, "R7 busy at start", int'(busy_o), 1);
        prev = int'(scale_o);
        cyc = 0; since = 0; bad = 0;
        while (int'(scale_o) != target && cyc < 30000) begin
            @(negedge clk);
            cyc++; since++;
            if (int'(scale_o) != prev) begin
                if (int'(scale_o) - prev != (up ? 1 : -1)) bad++;
                if (since != n) bad++;
                since = 0;
                prev = int'(scale_o);
            end
        end
        chk(cyc == 4095 * n, "R2 ramp duration", cyc, 4095 * n);
        chk(bad == 0, "R3 step size and spacing", bad, 0);
        repeat (2 * n + 3) @(negedge clk);
        chk(int'(scale_o) == target, "R9 end point held", int'(scale_o), target);
        chk(busy_o == 1'b0, "R7 busy low at end", int'(busy_o), 0);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int prev, expv, bad, s, sc;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; key_i = 1'b0; auto_en_i = 1'b1;
        manual_amp_i = '0; rate_i = 8'd1; sample_i = 12'd1000;
        repeat (3) @(negedge clk);
        chk(scale_o == 12'd0, "R1 scale in reset", int'(scale_o), 0);
        chk(busy_o == 1'b0, "R1 busy in reset", int'(busy_o), 0);
        chk(sample_o == 12'd0, "R1 sample in reset", int'(sample_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scale_o == 12'd0, "R1 scale after reset", int'(scale_o), 0);

        ramp_run(1'b1, 1, 1);   // R2 up, rate 1
        ramp_run(1'b0, 3, 3);   // R2 down, rate 3
        ramp_run(1'b1, 0, 1);   // R4 zero rate acts as one
        ramp_run(1'b0, 5, 5);   // R2 down, rate 5

        // R5: reversal mid-ramp at rate 2
        rate_i = 8'd2; key_i = 1'b1;
        repeat (1000) @(negedge clk);
        chk(int'(scale_o) == 500, "R3 level after 1000 cycles", int'(scale_o), 500);
        chk(busy_o == 1'b1, "R7 busy mid-ramp", int'(busy_o), 1);
        key_i = 1'b0;
        prev = int'(scale_o); bad = 0; cyc_blk: begin
            int c;
            c = 0;
            while (int'(scale_o) != 0 && c < 5000) begin
                @(negedge clk);
                c++;
                if (int'(scale_o) > prev || prev - int'(scale_o) > 1) bad++;
                prev = int'(scale_o);
            end
            chk(bad == 0, "R5 no jump on reversal", bad, 0);
            chk(c == 1000, "R5 reversal duration", c, 1000);
        end

        // R5: random key toggling at rate 1 against a per-cycle expectation
        rate_i = 8'd1;
        for (int i = 0; i < 3000; i++) begin
            prev = int'(scale_o);
            key_i = (($urandom % 4) != 0);
            @(negedge clk);
            expv = key_i ? ((prev < 4095) ? prev + 1 : 4095) : ((prev > 0) ? prev - 1 : 0);
            chk(int'(scale_o) == expv, "R5 random keying step", int'(scale_o), expv);
        end

        // R6: ramp keeps tracking the key while manual mode is selected
        key_i = 1'b0;
        repeat (4200) @(negedge clk);
        auto_en_i = 1'b0; key_i = 1'b1; manual_amp_i = 12'd77;
        repeat (100) @(negedge clk);
        chk(int'(scale_o) == 77, "R6 manual word on scale", int'(scale_o), 77);
        auto_en_i = 1'b1;
        #1;
        chk(int'(scale_o) == 100, "R6 background ramp level", int'(scale_o), 100);
        auto_en_i = 1'b0; key_i = 1'b0;

        // R8 directed corners, manual mode
        for (int k = 0; k < 4; k++) begin
            case (k)
                0: begin s = 2047;  sc = 4095; end
                1: begin s = -2048; sc = 4095; end
                2: begin s = -1;    sc = 1;    end
                default: begin s = 100; sc = 0; end
            endcase
            sample_i = 12'(s); manual_amp_i = 12'(sc);
            @(negedge clk);
            chk($signed(sample_o) == exp_prod(s, sc), "R8 corner product",
                int'($signed(sample_o)), exp_prod(s, sc));
        end

        // R6 and R8 random, manual mode
        for (int i = 0; i < 200; i++) begin
            manual_amp_i = 12'($urandom);
            sample_i = 12'($urandom);
            key_i = $urandom % 2;
            #1;
            chk(scale_o == manual_amp_i, "R6 manual passthrough",
                int'(scale_o), int'(manual_amp_i));
            s = int'($signed(sample_i)); sc = int'(scale_o);
            @(negedge clk);
            chk($signed(sample_o) == exp_prod(s, sc), "R8 random product",
                int'($signed(sample_o)), exp_prod(s, sc));
        end

        // R8 random, shaped mode with the ramp moving
        auto_en_i = 1'b1; key_i = 1'b1;
        for (int i = 0; i < 200; i++) begin
            sample_i = 12'($urandom);
            #1;
            s = int'($signed(sample_i)); sc = int'(scale_o);
            @(negedge clk);
            chk($signed(sample_o) == exp_prod(s, sc), "R8 shaped product",
                int'($signed(sample_o)), exp_prod(s, sc));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule